// File: doc/BRIEF.md
# Four-Error Sector ECC Correction Sequencer

This block drives the final stage of a four-symbol-correcting ECC over a 512-byte sector. When a sector has been read, software or a host controller pulses `start` and presents the ten ECC bytes that were stored with the sector and the four syndrome words that the ECC hardware produced. If the stored code is all ones, the sector is treated as erased. If the syndrome is all zero, the sector is clean. In both cases the block finishes at once with zero corrections.

Any other result needs the external error locator. The block first clears stale locator results with a one-cycle pulse, then starts the locator with a second one-cycle pulse. It then reads the locator's 4-bit status code. Right after a start, that status can falsely report completion. For this reason the block first waits for the locator to report "busy", or for a fixed guard time of 100 µs to pass, before it accepts a completion code.

On completion the block unpacks up to four error entries from two address registers and two value registers. It maps each raw address onto a byte of the sector, counting from the far end. Each byte that lies inside the sector is corrected by a read-modify-write XOR on a synchronous sector buffer, one error at a time. A one-cycle `done` pulse marks the end of the sequence. The corrected count and the uncorrectable flag stay valid until the next start.

Top module: `sector_fixup`

## Requirements
- R1: When all ten stored ECC bytes equal 0xFF, the block finishes with zero corrections. It issues no locator clear or start and makes no buffer access, whatever the syndrome is.
- R2: When the ECC bytes are not all 0xFF and all four 32-bit syndrome words are zero, the block finishes with zero corrections and does not use the locator.
- R3: In every other case the block drives `lc_clear` high for exactly one cycle. `lc_launch` follows for exactly one cycle, in the very next cycle.
- R4: After `lc_launch`, the block ignores any status code below 4. It keeps ignoring them until it sees a status of 4 or above, or until GUARD_US×CLK_MHZ cycles have passed, whichever comes first.
- R5: Status code 1 (five or more errors) sets `uncorrectable`, leaves `corrected` at zero and makes no buffer write.
- R6: Status code 0 after the guard finishes the sequence with zero corrections and the flag clear.
- R7: Status code 2 or 3 means results are ready. The number of errors is 1 plus the 2-bit `lc_nerr_m1` input.
- R8: Errors 0 and 1 come from `lc_addr_a`/`lc_val_a`, and errors 2 and 3 come from `lc_addr_b`/`lc_val_b`. Even-numbered errors use bits 15:0 and odd-numbered errors use bits 31:16. The address is the low 10 bits of its half, and the XOR value is the low 8 bits of its half.
- R9: The byte location is 519 minus the 10-bit raw address. A byte is written and counted only when the raw address lies in 8..519, that is, when the location lies in 0..511.
- R10: Each correction reads the buffer byte and, in the next cycle, writes back the read data XOR the value to the same address. Errors are handled strictly one at a time, in index order.
- R11: `done` is a one-cycle pulse. At that pulse `corrected` holds the final count. `corrected` and `uncorrectable` then hold until the next `start`.
- R12: While the status is 4 or above after the guard, the block keeps waiting and makes no buffer access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to correct the current sector |
| ecc_stored | input | 80 | Ten ECC bytes stored with the sector; byte k at bits 8k+7:8k |
| syndrome | input | 128 | Four 32-bit syndrome words |
| lc_status | input | 4 | Locator status code |
| lc_nerr_m1 | input | 2 | Error count minus one, from the locator status |
| lc_addr_a | input | 32 | Raw addresses of errors 0 (15:0) and 1 (31:16) |
| lc_addr_b | input | 32 | Raw addresses of errors 2 (15:0) and 3 (31:16) |
| lc_val_a | input | 32 | XOR values of errors 0 (15:0) and 1 (31:16) |
| lc_val_b | input | 32 | XOR values of errors 2 (15:0) and 3 (31:16) |
| lc_clear | output | 1 | One-cycle pulse discarding stale locator results |
| lc_launch | output | 1 | One-cycle pulse starting the locator |
| buf_addr | output | 9 | Sector buffer byte address |
| buf_rd_en | output | 1 | Buffer read strobe; data is returned next cycle |
| buf_rdata | input | 8 | Buffer read data |
| buf_we | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Buffer write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| corrected | output | 3 | Number of bytes corrected |
| uncorrectable | output | 1 | Locator reported too many errors |

## Verification
The hardest case to reach is the guard timeout. Here the locator never reports busy and shows a false "complete" code for the whole guard window. The bench holds the status at 3 from the launch pulse onward and measures how far `done` lands from the launch. It repeats the case with a short busy burst, to show that a busy code ends the guard early. Out-of-range raw addresses, addresses with garbage in the upper bits and two errors on the same byte are placed through the packed result registers. The byte-by-byte reference model shows whether each write uses the data left by the previous one.

// File: rtl/sfx_pkg.sv
// Shared types and constants for the sector fixup sequencer.
// Assumes a locator that reports a 4-bit status code.
package sfx_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_LAUNCH,
        ST_GUARD,
        ST_POLL,
        ST_FETCH,
        ST_READ,
        ST_WRITE,
        ST_FINISH
    } fix_state_t;

    localparam logic [3:0] CODE_CLEAN  = 4'd0;
    localparam logic [3:0] CODE_TOOMANY = 4'd1;
    localparam logic [3:0] CODE_BUSY_MIN = 4'd4;

endpackage

// File: rtl/sfx_screen.sv
// Early exit screen: flags an erased sector (all stored ECC bytes 0xFF)
// and a clean sector (all syndrome words zero). Purely combinational.
module sfx_screen #(
    parameter int ECC_BYTES = 10,
    parameter int SYN_WORDS = 4
) (
    input  logic [ECC_BYTES*8-1:0]  ecc_stored,
    input  logic [SYN_WORDS*32-1:0] syndrome,
    output logic                    erased,
    output logic                    syn_zero
);
    logic [ECC_BYTES-1:0] byte_ff;
    logic [SYN_WORDS-1:0] word_zero;

    // One comparator per stored byte.
    for (genvar i = 0; i < ECC_BYTES; i++) begin : g_byte
        assign byte_ff[i] = &ecc_stored[i*8 +: 8];
    end

    // One zero detector per syndrome word.
    for (genvar j = 0; j < SYN_WORDS; j++) begin : g_word
        assign word_zero[j] = ~|syndrome[j*32 +: 32];
    end

    assign erased   = &byte_ff;
    assign syn_zero = &word_zero;
endmodule

// File: rtl/sfx_guard.sv
// Guard timer: counts cycles spent in the guard phase and releases either
// when the locator shows a busy code or when the window has elapsed.
// Assumes run stays high for the whole guard phase.
module sfx_guard #(
    parameter int LIMIT = 12500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic busy_seen,
    output logic release_now
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    // Cycle counter, cleared whenever the guard phase is not active.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt != CW'(LIMIT - 1)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign release_now = run && (busy_seen || cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/sfx_unpack.sv
// Result unpacker: selects the address/value half-word of the current
// error and maps the raw 10-bit address onto a sector byte (offset - raw).
// Assumes result registers are stable while corrections run.
module sfx_unpack #(
    parameter int SECTOR = 512,
    parameter int AW     = 10,
    parameter int LW     = 9
) (
    input  logic [31:0]   addr_a,
    input  logic [31:0]   addr_b,
    input  logic [31:0]   val_a,
    input  logic [31:0]   val_b,
    input  logic [1:0]    idx,
    output logic [LW-1:0] loc,
    output logic [7:0]    val,
    output logic          in_range
);
    localparam int OFFSET = SECTOR + 7;

    logic [31:0]   areg, vreg;
    logic [15:0]   ahalf, vhalf;
    logic [AW-1:0] raw;
    logic          unused_bits;

    // Register pick by idx[1], half pick by idx[0].
    always_comb begin
        areg  = idx[1] ? addr_b : addr_a;
        vreg  = idx[1] ? val_b  : val_a;
        ahalf = idx[0] ? areg[31:16] : areg[15:0];
        vhalf = idx[0] ? vreg[31:16] : vreg[15:0];
        raw   = ahalf[AW-1:0];
        val   = vhalf[7:0];
        in_range = (raw >= AW'(OFFSET - SECTOR + 1)) && (raw <= AW'(OFFSET));
        loc   = LW'(AW'(OFFSET) - raw);
    end

    assign unused_bits = ^{ahalf[15:AW], vhalf[15:8]};
endmodule

// File: rtl/sector_fixup.sv
// Sector fixup sequencer: screens erased/clean sectors, clears and launches
// the external locator, enforces the guard window, polls the status, then
// XOR-corrects up to four bytes of a synchronous sector buffer one by one.
// Assumes buffer read data arrives one cycle after buf_rd_en.
module sector_fixup
    import sfx_pkg::*;
#(
    parameter int CLK_MHZ   = 125,
    parameter int GUARD_US  = 100,
    parameter int SECTOR    = 512,
    parameter int ECC_BYTES = 10,
    parameter int SYN_WORDS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [ECC_BYTES*8-1:0]  ecc_stored,
    input  logic [SYN_WORDS*32-1:0] syndrome,
    input  logic [3:0]              lc_status,
    input  logic [1:0]              lc_nerr_m1,
    input  logic [31:0]             lc_addr_a,
    input  logic [31:0]             lc_addr_b,
    input  logic [31:0]             lc_val_a,
    input  logic [31:0]             lc_val_b,
    output logic                    lc_clear,
    output logic                    lc_launch,
    output logic [$clog2(SECTOR)-1:0] buf_addr,
    output logic                    buf_rd_en,
    input  logic [7:0]              buf_rdata,
    output logic                    buf_we,
    output logic [7:0]              buf_wdata,
    output logic                    busy,
    output logic                    done,
    output logic [2:0]              corrected,
    output logic                    uncorrectable
);
    localparam int LW          = $clog2(SECTOR);
    localparam int GUARD_LIMIT = CLK_MHZ * GUARD_US;
    localparam int AGE_W       = $clog2(GUARD_LIMIT + 1);

    fix_state_t    state;
    logic          erased, syn_zero, guard_release;
    logic [1:0]    idx, last_idx;
    logic [LW-1:0] cur_loc, loc_q;
    logic [7:0]    cur_val, val_q;
    logic          cur_in_range;
    logic [2:0]    corr_q;
    logic          uncorr_q;

    sfx_screen #(.ECC_BYTES(ECC_BYTES), .SYN_WORDS(SYN_WORDS)) u_screen (
        .ecc_stored (ecc_stored),
        .syndrome   (syndrome),
        .erased     (erased),
        .syn_zero   (syn_zero)
    );

    sfx_guard #(.LIMIT(GUARD_LIMIT)) u_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (state == ST_GUARD),
        .busy_seen   (lc_status >= CODE_BUSY_MIN),
        .release_now (guard_release)
    );

    sfx_unpack #(.SECTOR(SECTOR), .AW(10), .LW(LW)) u_unpack (
        .addr_a   (lc_addr_a),
        .addr_b   (lc_addr_b),
        .val_a    (lc_val_a),
        .val_b    (lc_val_b),
        .idx      (idx),
        .loc      (cur_loc),
        .val      (cur_val),
        .in_range (cur_in_range)
    );

    // Main sequence: screen, locator handshake, guard, poll, corrections.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            idx      <= '0;
            last_idx <= '0;
            loc_q    <= '0;
            val_q    <= '0;
            corr_q   <= '0;
            uncorr_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        corr_q   <= '0;
                        uncorr_q <= 1'b0;
                        state    <= (erased || syn_zero) ? ST_FINISH : ST_CLEAR;
                    end
                end
                ST_CLEAR:  state <= ST_LAUNCH;
                ST_LAUNCH: state <= ST_GUARD;
                ST_GUARD: begin
                    if (guard_release) state <= ST_POLL;
                end
                ST_POLL: begin
                    if (lc_status == CODE_CLEAN) begin
                        state <= ST_FINISH;
                    end else if (lc_status == CODE_TOOMANY) begin
                        uncorr_q <= 1'b1;
                        state    <= ST_FINISH;
                    end else if (lc_status < CODE_BUSY_MIN) begin
                        last_idx <= lc_nerr_m1;
                        idx      <= '0;
                        state    <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    loc_q <= cur_loc;
                    val_q <= cur_val;
                    if (cur_in_range) begin
                        state <= ST_READ;
                    end else if (idx == last_idx) begin
                        state <= ST_FINISH;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_READ: state <= ST_WRITE;
                ST_WRITE: begin
                    corr_q <= corr_q + 1'b1;
                    if (idx == last_idx) begin
                        state <= ST_FINISH;
                    end else begin
                        idx   <= idx + 1'b1;
                        state <= ST_FETCH;
                    end
                end
                ST_FINISH: state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // Output decode from the current state.
    always_comb begin
        lc_clear      = (state == ST_CLEAR);
        lc_launch     = (state == ST_LAUNCH);
        buf_rd_en     = (state == ST_READ);
        buf_we        = (state == ST_WRITE);
        buf_addr      = loc_q;
        buf_wdata     = buf_rdata ^ val_q;
        busy          = (state != ST_IDLE);
        done          = (state == ST_FINISH);
        corrected     = corr_q;
        uncorrectable = uncorr_q;
    end

    // Independent age counter for the guard check below.
    logic [AGE_W-1:0] guard_age;
    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_GUARD) begin
            guard_age <= '0;
        end else if (guard_age != AGE_W'(GUARD_LIMIT)) begin
            guard_age <= guard_age + 1'b1;
        end
    end

    p_launch_after_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lc_launch |-> $past(lc_clear));

    p_clear_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lc_clear |=> !lc_clear);

    p_guard_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state == ST_GUARD) && state == ST_POLL && $past(lc_status) < CODE_BUSY_MIN)
        |-> $past(guard_age) >= AGE_W'(GUARD_LIMIT - 1));

    p_no_write_uncorr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        uncorrectable |-> !buf_we && corrected == 3'd0);

    p_write_follows_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> $past(buf_rd_en) && $stable(buf_addr));

    p_single_action_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({buf_we, buf_rd_en, lc_clear, lc_launch, done}));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && $stable(corrected) && $stable(uncorrectable));

    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> corrected <= 3'd4);
endmodule

// File: tb/sector_fixup_test.sv
module sector_fixup_test;
    localparam int GUARD = 125 * 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [79:0]  ecc_stored = '0;
    logic [127:0] syndrome = '0;
    logic [3:0]   lc_status = 4'd0;
    logic [1:0]   lc_nerr_m1 = 2'd0;
    logic [31:0]  lc_addr_a = '0, lc_addr_b = '0, lc_val_a = '0, lc_val_b = '0;
    logic lc_clear, lc_launch, buf_rd_en, buf_we, busy, done, uncorrectable;
    logic [8:0] buf_addr;
    logic [7:0] buf_rdata = 8'd0, buf_wdata;
    logic [2:0] corrected;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sector_fixup uut (
        .clk(clk), .rst_n(rst_n), .start(start), .ecc_stored(ecc_stored),
        .syndrome(syndrome), .lc_status(lc_status), .lc_nerr_m1(lc_nerr_m1),
        .lc_addr_a(lc_addr_a), .lc_addr_b(lc_addr_b), .lc_val_a(lc_val_a),
        .lc_val_b(lc_val_b), .lc_clear(lc_clear), .lc_launch(lc_launch),
        .buf_addr(buf_addr), .buf_rd_en(buf_rd_en), .buf_rdata(buf_rdata),
        .buf_we(buf_we), .buf_wdata(buf_wdata), .busy(busy), .done(done),
        .corrected(corrected), .uncorrectable(uncorrectable)
    );

    // Sector buffer with synchronous read, and its shadow in the model.
    logic [7:0] mem [512];
    int shadow [512];
    always @(posedge clk) begin
        if (buf_rd_en) buf_rdata <= mem[buf_addr];
        if (buf_we) mem[buf_addr] <= buf_wdata;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference model state: expected write sequence and locator timing.
    int q_addr[$];
    int q_data[$];
    int ph_a_val, ph_a_len, ph_b_val, ph_b_len, ph_final;
    int st_cnt = 0;
    bit st_active = 0;
    bit prev_clear = 0;
    int n_clear = 0, n_launch = 0, n_access = 0;
    int cyc = 0, launch_cyc = 0;

    // Per-clock comparison of the outputs against the model.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (buf_we) begin
                if (q_addr.size() == 0) begin
                    check(0, "R9 unexpected write", int'(buf_addr), -1);
                end else begin
                    check(int'(buf_addr) == q_addr[0], "R10 write address", int'(buf_addr), q_addr[0]);
                    check(int'(buf_wdata) == q_data[0], "R8 write data", int'(buf_wdata), q_data[0]);
                    void'(q_addr.pop_front());
                    void'(q_data.pop_front());
                end
            end
            if (buf_we || buf_rd_en) n_access++;
            if (lc_clear) n_clear++;
            if (lc_launch) begin
                n_launch++;
                check(prev_clear, "R3 clear precedes launch", 0, 1);
                st_active = 1;
                st_cnt = 0;
                launch_cyc = cyc;
            end else if (st_active) begin
                st_cnt++;
            end
            if (st_active) begin
                if (st_cnt < ph_a_len) lc_status = 4'(ph_a_val);
                else if (st_cnt < ph_a_len + ph_b_len) lc_status = 4'(ph_b_val);
                else lc_status = 4'(ph_final);
            end
            prev_clear = lc_clear;
        end
    end

    task automatic run_case(input string name, input logic [79:0] ecc, input logic [127:0] syn,
                            input int a_v, input int a_n, input int b_v, input int b_n, input int fin,
                            input int nm1, input logic [31:0] aa, input logic [31:0] ab,
                            input logic [31:0] va, input logic [31:0] vb,
                            output int elapsed);
        int exp_corr;
        bit exp_unc, uses_loc;
        int wait_n;
        exp_corr = 0;
        exp_unc = 0;
        uses_loc = !(&ecc) && (syn != '0);
        // Model the expected corrections (R7, R8, R9).
        if (uses_loc && (fin == 2 || fin == 3)) begin
            for (int i = 0; i <= nm1; i++) begin
                logic [31:0] ar, vr;
                logic [15:0] ah, vh;
                int raw, loc;
                ar = (i >= 2) ? ab : aa;
                vr = (i >= 2) ? vb : va;
                ah = (i % 2 == 1) ? ar[31:16] : ar[15:0];
                vh = (i % 2 == 1) ? vr[31:16] : vr[15:0];
                raw = int'(ah[9:0]);
                loc = 519 - raw;
                if (loc >= 0 && loc < 512) begin
                    shadow[loc] = shadow[loc] ^ int'(vh[7:0]);
                    q_addr.push_back(loc);
                    q_data.push_back(shadow[loc]);
                    exp_corr++;
                end
            end
        end
        if (uses_loc && fin == 1) exp_unc = 1;
        ph_a_val = a_v; ph_a_len = a_n; ph_b_val = b_v; ph_b_len = b_n; ph_final = fin;
        st_active = 0;
        lc_status = 4'd0;
        n_clear = 0; n_launch = 0; n_access = 0;
        ecc_stored = ecc; syndrome = syn; lc_nerr_m1 = 2'(nm1);
        lc_addr_a = aa; lc_addr_b = ab; lc_val_a = va; lc_val_b = vb;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_n = 0;
        while (!done && wait_n < 20000) begin
            @(negedge clk);
            wait_n++;
        end
        elapsed = cyc - launch_cyc;
        check(done == 1'b1, {name, " R11 done seen"}, int'(done), 1);
        check(int'(corrected) == exp_corr, {name, " R9 corrected count"}, int'(corrected), exp_corr);
        check(uncorrectable == exp_unc, {name, " R5 uncorrectable"}, int'(uncorrectable), int'(exp_unc));
        check(q_addr.size() == 0, {name, " R10 all writes issued"}, q_addr.size(), 0);
        if (!uses_loc) begin
            check(n_clear == 0 && n_launch == 0, {name, " R1 R2 locator untouched"}, n_clear + n_launch, 0);
            check(n_access == 0, {name, " R1 R2 no buffer access"}, n_access, 0);
        end else begin
            check(n_clear == 1 && n_launch == 1, {name, " R3 single clear and launch"}, n_clear * 10 + n_launch, 11);
        end
        if (exp_unc) check(n_access == 0, {name, " R5 no buffer access"}, n_access, 0);
        repeat (3) @(negedge clk);
        check(!done && int'(corrected) == exp_corr, {name, " R11 result held"}, int'(corrected), exp_corr);
        st_active = 0;
        q_addr.delete();
        q_data.delete();
    endtask

    localparam logic [79:0]  ECC_ERASED = {80{1'b1}};
    localparam logic [79:0]  ECC_USED   = 80'h1234_5678_9abc_def0_1122;
    localparam logic [127:0] SYN_DIRTY  = 128'h0000_0001_0000_0000_0000_0000_0000_0000;

    // Watchdog: a hung run is one failed check, then the summary.
    initial begin
        #(8 * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int el;
        for (int i = 0; i < 512; i++) begin
            mem[i] = 8'((i * 7 + 3) & 8'hff);
            shadow[i] = (i * 7 + 3) & 8'hff;
        end
        ph_a_val = 0; ph_a_len = 0; ph_b_val = 0; ph_b_len = 0; ph_final = 0;
        repeat (3) @(negedge clk);
        check(!busy && !done && corrected == 3'd0 && !uncorrectable && !lc_clear && !lc_launch
              && !buf_we && !buf_rd_en, "R11 reset state", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: erased page, syndrome ignored.
        run_case("erased", ECC_ERASED, SYN_DIRTY, 3, 0, 0, 0, 3, 0, 32'h0000_0107, 0, 32'h55, 0, el);
        // R2: clean syndrome.
        run_case("clean", ECC_USED, '0, 3, 0, 0, 0, 3, 0, 32'h0000_0107, 0, 32'h55, 0, el);
        // R5: too many errors, after a busy burst.
        run_case("toomany", ECC_USED, SYN_DIRTY, 8, 2, 0, 0, 1, 3, 32'h0008_0107, 0, 32'h55, 0, el);
        // R6: status 0 after the guard.
        run_case("nofix", ECC_USED, SYN_DIRTY, 9, 3, 0, 0, 0, 0, 32'h0000_0107, 0, 32'h77, 0, el);
        // R7 R8 R10: four in-range errors, locations 0, 511, 100, 300.
        run_case("four", ECC_USED, SYN_DIRTY, 12, 4, 0, 0, 3, 3,
                 {16'd8, 16'd519}, {16'd219, 16'd419}, {16'h00a5, 16'h0011}, {16'h0042, 16'h0f3c}, el);
        // R9: out-of-range raw 5 and 600, masked upper bits on raw 519.
        run_case("range", ECC_USED, SYN_DIRTY, 4, 1, 0, 0, 2, 2,
                 {16'd5, 16'hfc00 | 16'd519}, {16'h0000, 16'd600}, {16'h00ff, 16'hab01}, {16'h0, 16'h0099}, el);
        // R10: same byte twice, second write uses first result.
        run_case("dup", ECC_USED, SYN_DIRTY, 5, 2, 0, 0, 2, 2,
                 {16'd400, 16'd400}, {16'h0, 16'd401}, {16'h000f, 16'h00f0}, {16'h0, 16'h0081}, el);
        // R4 R12: false ready, then busy ends the guard early, busy again then ready.
        run_case("early", ECC_USED, SYN_DIRTY, 3, 5, 10, 6, 2, 1,
                 {16'd300, 16'd200}, 0, {16'h0033, 16'h0044}, 0, el);
        check(el < 40, "R4 busy code ends guard early", el, 40);
        check(el >= 11, "R12 waits while busy", el, 11);
        // R4: status stuck at 3, only the timeout ends the guard.
        run_case("timeout", ECC_USED, SYN_DIRTY, 3, 0, 0, 0, 3, 0,
                 {16'd0, 16'd10}, 0, {16'h0, 16'h00c3}, 0, el);
        check(el >= GUARD, "R4 guard window respected", el, GUARD);
        check(el <= GUARD + 8, "R4 guard window bounded", el, GUARD + 8);

        for (int i = 0; i < 512; i++) begin
            if (int'(mem[i]) != shadow[i]) check(0, "R10 buffer contents", int'(mem[i]), shadow[i]);
        end
        checks++;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule